// File: doc/BRIEF.md
# Pad Receive Event Detector Bank

This block sits on the receive side of a bank of general-purpose pads, between the raw pad input and the interrupt logic. Each pad's input is brought into the clock domain by a synchroniser chain. An optional inversion is then applied, and the result is turned into an event output. Depending on the pad's mode, that output is a level or a single-cycle pulse. The block also produces the synchronised, non-inverted pad value for status readback.

Each pad has its own configuration. It is loaded from a shared 32-bit configuration word when that pad's write strobe is high. The word carries a 2-bit event mode, an invert bit and a receive-disable bit. Falling-edge detection is rising-edge mode with invert set, and active-low level detection is level mode with invert set. Any change in either direction has its own mode code.

A configuration write also reloads the previous-sample register of the edge detector, using the new settings. Changing the mode, the invert bit or the receive-disable bit therefore never produces an event by itself.

Top module: `rxev_bank`

## Requirements
- R1: After synchronous reset, rx_state and evt are 0 for every pad. Every pad's configuration is event mode 2 (off), invert 0 and receive enabled.
- R2: When cfg_we[i] is high at a clock edge, pad i loads its configuration from cfg_wdata: bits 26:25 are the event mode, bit 23 is invert and bit 9 is receive-disable. Pads whose strobe is low keep their configuration.
- R3: rx_state[i] is the synchronised pad input and is not affected by invert. It changes on the third clock edge after pad_in changes, and it reads 0 while receive-disable is set.
- R4: In event mode 0 (level), evt[i] is high while the received value (pad XOR invert) is 1. This gives active-high detection without invert and active-low detection with invert, with the same three-edge latency as rx_state.
- R5: In event mode 1 (edge), a 0-to-1 transition of the received value gives exactly one cycle of evt[i] high. With invert set, this is a falling edge on the pad.
- R6: In event mode 3 (both edges), every transition of the received value gives exactly one cycle of evt[i] high.
- R7: In event mode 2 (off), evt[i] stays 0 whatever the pad does.
- R8: While receive-disable is set, evt[i] and rx_state[i] stay 0.
- R9: A configuration write while the pad input is steady produces no event in edge or both-edge mode. This holds when the write flips invert and when it clears receive-disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | N_PADS | Raw asynchronous pad inputs |
| cfg_we | input | N_PADS | Per-pad configuration write strobe |
| cfg_wdata | input | 32 | Shared configuration word |
| rx_state | output | N_PADS | Synchronised pad values for readback |
| evt | output | N_PADS | Event level or pulse per pad |

## Verification
The hardest case to reach is a configuration write that would, without the reload, create a false edge. This requires the pad to be steady at a value whose received polarity flips, or whose received value jumps from forced-0 to 1 when receive is re-enabled. The table of stimulus vectors settles the pad under the old settings first. It then writes the new settings and counts events over a window that starts at the first edge governed by the new settings. Several rows chain together so that one row's end state is the next row's starting state.

// File: rtl/rxev_pkg.sv
package rxev_pkg;
  localparam int CFG_W     = 32;
  localparam int MODE_LSB  = 25;
  localparam int INV_BIT   = 23;
  localparam int RXDIS_BIT = 9;

  typedef enum logic [1:0] {
    EVM_LEVEL = 2'd0,
    EVM_RISE  = 2'd1,
    EVM_OFF   = 2'd2,
    EVM_ANY   = 2'd3
  } evmode_e;

  typedef struct packed {
    evmode_e mode;
    logic    inv;
    logic    dis;
  } padcfg_t;

  function automatic padcfg_t decode_cfg(input logic [CFG_W-1:0] w);
    padcfg_t c;
    c.mode = evmode_e'(w[MODE_LSB+1:MODE_LSB]);
    c.inv  = w[INV_BIT];
    c.dis  = w[RXDIS_BIT];
    return c;
  endfunction
endpackage

// File: rtl/rxev_sync.sv
module rxev_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/rxev_pad_detect.sv
module rxev_pad_detect
  import rxev_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rx_sync,
  input  logic    cfg_we,
  input  padcfg_t cfg_in,
  output logic    rx_o,
  output logic    evt_o
);
  padcfg_t cfg_q;
  logic    prev_q;
  logic    cur;
  logic    cur_new;
  logic    evt_n;

  always_comb begin
    cur     = cfg_q.dis ? 1'b0 : (rx_sync ^ cfg_q.inv);
    cur_new = cfg_in.dis ? 1'b0 : (rx_sync ^ cfg_in.inv);
    unique case (cfg_q.mode)
      EVM_LEVEL: evt_n = cur;
      EVM_RISE:  evt_n = cur & ~prev_q;
      EVM_ANY:   evt_n = cur ^ prev_q;
      default:   evt_n = 1'b0;
    endcase
    if (cfg_q.dis) evt_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.mode <= EVM_OFF;
      cfg_q.inv  <= 1'b0;
      cfg_q.dis  <= 1'b0;
      prev_q     <= 1'b0;
      rx_o       <= 1'b0;
      evt_o      <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q  <= cfg_in;
        prev_q <= cur_new;
      end else begin
        prev_q <= cur;
      end
      rx_o  <= cfg_q.dis ? 1'b0 : rx_sync;
      evt_o <= evt_n;
    end
  end

  // R7: the off mode never yields an event
  assert_mode_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.mode == EVM_OFF) |=> !evt_o);

  // R8: receive-disable silences both outputs
  assert_rxdis_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_q.dis |=> (!evt_o && !rx_o));

  // R9: after a write, a steady input leaves detector history equal to current value
  assert_cfg_reload_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we ##1 (rx_sync == $past(rx_sync))) |-> (cur == prev_q));

  // R4: level mode output tracks the readback value with polarity applied
  assert_level_follow_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.mode == EVM_LEVEL && !cfg_q.dis && !cfg_we) |=> (evt_o == (rx_o ^ cfg_q.inv)));

  // R5: an edge-mode event only appears with the pad at its active level
  assert_edge_polarity_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.mode == EVM_RISE && !cfg_q.dis && !cfg_we) |=> (!evt_o || (rx_o != cfg_q.inv)));
endmodule

// File: rtl/rxev_bank.sv
module rxev_bank
  import rxev_pkg::*;
#(
  parameter int N_PADS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PADS-1:0] pad_in,
  input  logic [N_PADS-1:0] cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [N_PADS-1:0] rx_state,
  output logic [N_PADS-1:0] evt
);
  logic [N_PADS-1:0] pad_sync;
  padcfg_t           cfg_dec;

  assign cfg_dec = decode_cfg(cfg_wdata);

  rxev_sync #(
    .WIDTH  (N_PADS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pad_in),
    .q_out (pad_sync)
  );

  generate
    for (genvar p = 0; p < N_PADS; p++) begin : g_pad
      rxev_pad_detect u_det (
        .clk     (clk),
        .rst     (rst),
        .rx_sync (pad_sync[p]),
        .cfg_we  (cfg_we[p]),
        .cfg_in  (cfg_dec),
        .rx_o    (rx_state[p]),
        .evt_o   (evt[p])
      );
    end
  endgenerate

  // R1: outputs are clear on the first cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rx_state == '0 && evt == '0));
endmodule

// File: tb/tb_rxev_bank.sv
module tb_rxev_bank;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] cfg_we = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [NP-1:0] rx_state;
  logic [NP-1:0] evt;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  rxev_bank #(.N_PADS(NP), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .pad_in(pad_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .rx_state(rx_state), .evt(evt)
  );

  always #4 clk = ~clk;

  // fields: mode[11:10] inv[9] dis[8] before[7] after[6] count[5:2] rx[1] evt[0]
  localparam int NV = 17;
  localparam logic [11:0] VEC [NV] = '{
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 1'b0},  // R5 rising
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0},  // R5 fall ignored
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0, 1'b0},  // R5 falling via invert
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 1'b0},  // R5 inverted rise ignored
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 1'b0},  // R6 rise
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0, 1'b0},  // R6 fall
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6, 1'b1, 1'b1},  // R4 active high
    {2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6, 1'b0, 1'b1},  // R4 active low
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5, 1'b1, 1'b0},  // R4 active low, released
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 1'b0},  // R7 off
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0},  // R8 disabled
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},  // R9 setup
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},  // R9 invert flip, edge
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},  // R9 mode change
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},  // R9 invert flip, both
    {2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0},  // R8 disabled, pad high
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b1, 1'b0}   // R9 re-enable, pad high
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(input logic [1:0] m, input logic inv, input logic dis);
    logic [31:0] w;
    w = '0;
    w[26:25] = m;
    w[23] = inv;
    w[9] = dis;
    return w;
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    int c1, c2, c3, c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rx_state == '0 && evt == '0, "R1 reset outputs", int'({rx_state, evt}), 0);

    // R1: reset mode is off -> pad rise gives no event, but readback follows
    pad_in = '1;
    cnt = 0;
    repeat (8) begin @(negedge clk); cnt += int'($countones(evt)); end
    check(cnt == 0, "R1 default mode off", cnt, 0);
    check(rx_state == '1, "R3 readback after reset", int'(rx_state), 15);
    pad_in = '0;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      pad_in[0] = v[7];
      repeat (5) @(negedge clk);
      cfg_wdata = mkcfg(v[11:10], v[9], v[8]);
      cfg_we = 4'b0001;
      @(negedge clk);
      cfg_we = '0;
      cfg_wdata = '0;
      cnt = 0;
      repeat (3) begin @(negedge clk); cnt += int'(evt[0]); end
      pad_in[0] = v[6];
      repeat (8) begin @(negedge clk); cnt += int'(evt[0]); end
      check(cnt == int'(v[5:2]), $sformatf("R2/R4-R9 row %0d event count", i), cnt, int'(v[5:2]));
      check(rx_state[0] == v[1], $sformatf("R3 row %0d readback", i), int'(rx_state[0]), int'(v[1]));
      check(evt[0] == v[0], $sformatf("R4 row %0d final event", i), int'(evt[0]), int'(v[0]));
    end

    // R3: latency of readback is three edges
    pad_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    pad_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rx_state[0] == 1'b0, "R3 not yet after two edges", int'(rx_state[0]), 0);
    @(negedge clk);
    check(rx_state[0] == 1'b1, "R3 visible after three edges", int'(rx_state[0]), 1);

    // R2: write to pad 2 only; pads 1 and 3 stay off, pad 0 keeps edge mode
    pad_in = 4'b0001;
    repeat (5) @(negedge clk);
    cfg_wdata = mkcfg(2'd1, 1'b0, 1'b0);
    cfg_we = 4'b0100;
    @(negedge clk);
    cfg_we = '0;
    cfg_wdata = '0;
    pad_in = 4'b1111;
    c0 = 0; c1 = 0; c2 = 0; c3 = 0;
    repeat (8) begin
      @(negedge clk);
      c0 += int'(evt[0]); c1 += int'(evt[1]);
      c2 += int'(evt[2]); c3 += int'(evt[3]);
    end
    check(c2 == 1, "R2 written pad 2 edge", c2, 1);
    check(c1 == 0, "R2 unwritten pad 1 stays off", c1, 0);
    check(c3 == 0, "R2 unwritten pad 3 stays off", c3, 0);
    check(c0 == 0, "R2 pad 0 steady, no event", c0, 0);

    // R1: mid-run reset returns pad 2 to off mode
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(rx_state == '0 && evt == '0, "R1 reset mid-run", int'({rx_state, evt}), 0);
    pad_in = 4'b0000;
    repeat (5) @(negedge clk);
    pad_in = 4'b0100;
    cnt = 0;
    repeat (8) begin @(negedge clk); cnt += int'(evt[2]); end
    check(cnt == 0, "R1 mode off after reset", cnt, 0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule